// File: doc/BRIEF.md
# Interrupt Ring Packet Writer

This block takes interrupt requests from a set of client engines, holds them in an arrival-ordered queue and turns each one into a 32-byte interrupt packet. It writes the packet by DMA into a ring buffer in system memory, at the ring base address plus the current write offset. It then advances the write offset and writes the new offset by a second DMA to a write-back location. Only after that second write completes does it pulse the host interrupt line.

The host sets up the ring through a 32-bit register write port. It frees ring space by returning its read offset, either with a plain register write or through a doorbell write. If adding one more packet would make the write offset catch up with the read offset, the block reports the ring as full and holds the next packet back until the read offset moves.

Top module: `irq_ring_writer`

## Requirements
- R1: Register writes (`cfg_wr_off`) follow this map. 0 sets the ring size field from bits 3:0, giving a ring of 32<<n bytes, with n clamped to SZ_MAX. 1 loads the ring base as the value shifted left by 8, replacing the old base. 2 ORs bits 23:0 of the value into base bits 63:40. 3 and 4 are plain stores of the read and write offsets. 5 and 6 are the low and high words of the write-back address. 7 is the doorbell setup.
- R2: A packet write is issued with `dma_req_addr` = ring base + write offset, `dma_req_len` = 32 and `dma_req_tag` = 1. The request stays asserted and unchanged until `dma_req_accept`.
- R3: The packet is eight 32-bit words, with word k at bits 32k+31:32k. Word 0 holds the client ID in bits 7:0, the source ID in bits 15:8 and the ring ID in bits 23:16. Word 1 is 0x40. Word 3 is 0x8000. Word 5 is the request context value. Every other bit is zero.
- R4: A completion with tag 1 advances the write offset by 32, modulo the ring size. The block then issues a 4-byte write with tag 2 to the write-back address {word 6, word 5}, carrying the new offset in data bits 31:0.
- R5: `host_irq` is a one-cycle pulse. It rises in the cycle after a tag-2 completion and never earlier in the sequence.
- R6: A completion whose tag does not match the phase being waited for pulses `dma_err` one cycle later. The block keeps waiting for the correct tag and issues nothing new.
- R7: Only these client IDs are accepted: 0x01, 0x10 to 0x17, and 0x20. Only these source IDs are accepted: 0x05 (end of pipe) and 0x0A (trap). Any other request is taken off the port and discarded without any DMA.
- R8: Accepted requests are serviced strictly in arrival order, one full sequence at a time. `req_ready` goes low when the FIFO_DEPTH-entry queue is full.
- R9: When (write offset + 32) mod ring size equals the read offset, `ring_full` is high and no packet write starts until the read offset changes.
- R10: A doorbell setup write keeps bits 25:0 as the doorbell offset and bit 28 as the enable. While the doorbell is enabled, a doorbell write whose offset matches loads the read offset. Otherwise a doorbell write has no effect.
- R11: During reset `req_ready` is high and `dma_req_valid`, `host_irq`, `ring_full` and `dma_err` are low.
- R12: Register writes to offsets 8 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_off | input | 4 | Register word offset |
| cfg_wr_data | input | 32 | Register write value |
| db_valid | input | 1 | Doorbell write strobe |
| db_offset | input | 26 | Doorbell offset of the write |
| db_data | input | 32 | Read offset carried by the doorbell |
| req_valid | input | 1 | Interrupt request valid |
| req_ready | output | 1 | Request queue can take a request |
| req_client | input | 8 | Client ID |
| req_source | input | 8 | Source ID |
| req_ring | input | 8 | Ring ID |
| req_ctx | input | 32 | Requester context value |
| dma_req_valid | output | 1 | DMA write request valid |
| dma_req_accept | input | 1 | DMA request taken |
| dma_req_addr | output | 64 | DMA byte address |
| dma_req_data | output | 256 | DMA write data |
| dma_req_len | output | 6 | DMA length in bytes |
| dma_req_tag | output | 2 | Phase tag, 1 packet, 2 pointer |
| dma_done | input | 1 | DMA completion strobe |
| dma_done_tag | input | 2 | Tag of the completed write |
| host_irq | output | 1 | Host interrupt pulse |
| ring_full | output | 1 | Ring has no room for another packet |
| dma_err | output | 1 | Unexpected completion tag pulse |

## Verification
The bench goes after the edges of the ring. It fills a four-entry ring until the next write offset meets the read offset, so a design that compares against the wrong offset would overwrite unread entries or stall one slot early. It also checks that a packet at the top of the ring sends the write-back data back to zero, which catches a wrap computed against the wrong size. It sends a completion with a bogus tag in the middle of a sequence, where a lax design would move on to the pointer phase or raise the interrupt early. It also covers IDs just outside the legal sets, a doorbell that is disabled or carries the wrong offset, and writes to unused offsets; a design that decodes any of these loosely would issue packets or move the base address.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;
  localparam int PKT_BYTES = 32;
  localparam int PKT_BITS  = PKT_BYTES * 8;
  localparam int ADDR_W    = 64;
  localparam int LEN_W     = 6;
  localparam int TAG_W     = 2;
  localparam int OFF_W     = 4;
  localparam int DB_OFF_W  = 26;
  localparam int DB_EN_BIT = 28;

  localparam logic [OFF_W-1:0] OFF_CTRL   = 4'd0;
  localparam logic [OFF_W-1:0] OFF_BASE_L = 4'd1;
  localparam logic [OFF_W-1:0] OFF_BASE_H = 4'd2;
  localparam logic [OFF_W-1:0] OFF_RDOFS  = 4'd3;
  localparam logic [OFF_W-1:0] OFF_WROFS  = 4'd4;
  localparam logic [OFF_W-1:0] OFF_WB_L   = 4'd5;
  localparam logic [OFF_W-1:0] OFF_WB_H   = 4'd6;
  localparam logic [OFF_W-1:0] OFF_DBELL  = 4'd7;

  localparam logic [TAG_W-1:0] TAG_PKT = 2'd1;
  localparam logic [TAG_W-1:0] TAG_PTR = 2'd2;

  localparam logic [7:0] CLI_CTRL     = 8'h01;
  localparam logic [7:0] CLI_DMA_BASE = 8'h10;
  localparam logic [7:0] CLI_CMDP     = 8'h20;
  localparam logic [7:0] SRC_EOP      = 8'h05;
  localparam logic [7:0] SRC_TRAP     = 8'h0A;

  localparam logic [31:0] PKT_PROC_ID = 32'h0000_8000;
  localparam logic [31:0] PKT_STAMP   = 32'h0000_0040;

  typedef struct packed {
    logic [7:0]  client;
    logic [7:0]  source;
    logic [7:0]  ring;
    logic [31:0] ctx;
  } irq_req_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_PKT_REQ, ST_PKT_WAIT, ST_PTR_REQ, ST_PTR_WAIT
  } wr_state_t;

  function automatic logic req_legal(irq_req_t r);
    logic cli_ok, src_ok;
    cli_ok = (r.client == CLI_CTRL) || (r.client == CLI_CMDP) ||
             (r.client[7:3] == CLI_DMA_BASE[7:3]);
    src_ok = (r.source == SRC_EOP) || (r.source == SRC_TRAP);
    return cli_ok && src_ok;
  endfunction
endpackage

// File: rtl/irq_req_fifo.sv
module irq_req_fifo #(
  parameter int W     = 56,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop && !empty) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end
endmodule

// File: rtl/irq_ring_regs.sv
module irq_ring_regs
  import irq_ring_pkg::*;
#(
  parameter int SZ_W   = 4,
  parameter int SZ_MAX = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [OFF_W-1:0]    wr_off,
  input  logic [31:0]         wr_data,
  input  logic                db_valid,
  input  logic [DB_OFF_W-1:0] db_offset,
  input  logic [31:0]         db_data,
  input  logic                adv_en,
  output logic [ADDR_W-1:0]   base,
  output logic [ADDR_W-1:0]   wb_addr,
  output logic [31:0]         wptr,
  output logic [31:0]         rptr,
  output logic [31:0]         wptr_next
);
  logic [SZ_W-1:0]     size_q, size_eff;
  logic [31:0]         wb_lo, wb_hi;
  logic [DB_OFF_W-1:0] db_off_q;
  logic                db_en_q;
  logic [31:0]         ring_mask;

  assign size_eff  = (size_q > SZ_W'(SZ_MAX)) ? SZ_W'(SZ_MAX) : size_q;
  assign ring_mask = (32'(PKT_BYTES) << size_eff) - 32'd1;
  assign wptr_next = (wptr + 32'(PKT_BYTES)) & ring_mask;
  assign wb_addr   = {wb_hi, wb_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q   <= '0;
      base     <= '0;
      wb_lo    <= '0;
      wb_hi    <= '0;
      wptr     <= '0;
      rptr     <= '0;
      db_off_q <= '0;
      db_en_q  <= 1'b0;
    end else begin
      if (adv_en) wptr <= wptr_next;
      if (db_valid && db_en_q && (db_offset == db_off_q)) rptr <= db_data;
      if (wr_en) begin
        unique case (wr_off)
          OFF_CTRL:   size_q <= wr_data[SZ_W-1:0];
          OFF_BASE_L: base   <= {24'h0, wr_data, 8'h0};
          OFF_BASE_H: base   <= base | {wr_data[23:0], 40'h0};
          OFF_RDOFS:  rptr   <= wr_data;
          OFF_WROFS:  wptr   <= wr_data;
          OFF_WB_L:   wb_lo  <= wr_data;
          OFF_WB_H:   wb_hi  <= wr_data;
          OFF_DBELL: begin
            db_off_q <= wr_data[DB_OFF_W-1:0];
            db_en_q  <= wr_data[DB_EN_BIT];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_pkt_pack.sv
module irq_pkt_pack
  import irq_ring_pkg::*;
(
  input  irq_req_t            req,
  output logic [PKT_BITS-1:0] pkt
);
  localparam int WORDS = PKT_BITS / 32;
  logic [31:0] word [WORDS];

  always_comb begin
    for (int k = 0; k < WORDS; k++) word[k] = 32'h0;
    word[0] = {8'h00, req.ring, req.source, req.client};
    word[1] = PKT_STAMP;
    word[3] = PKT_PROC_ID;
    word[5] = req.ctx;
  end

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_pack
      assign pkt[32*g +: 32] = word[g];
    end
  endgenerate
endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
  import irq_ring_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SZ_MAX     = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_en,
  input  logic [OFF_W-1:0]    cfg_wr_off,
  input  logic [31:0]         cfg_wr_data,
  input  logic                db_valid,
  input  logic [DB_OFF_W-1:0] db_offset,
  input  logic [31:0]         db_data,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [7:0]          req_client,
  input  logic [7:0]          req_source,
  input  logic [7:0]          req_ring,
  input  logic [31:0]         req_ctx,
  output logic                dma_req_valid,
  input  logic                dma_req_accept,
  output logic [ADDR_W-1:0]   dma_req_addr,
  output logic [PKT_BITS-1:0] dma_req_data,
  output logic [LEN_W-1:0]    dma_req_len,
  output logic [TAG_W-1:0]    dma_req_tag,
  input  logic                dma_done,
  input  logic [TAG_W-1:0]    dma_done_tag,
  output logic                host_irq,
  output logic                ring_full,
  output logic                dma_err
);
  localparam int REQ_W = $bits(irq_req_t);

  irq_req_t            in_req, head_req;
  logic                fifo_empty, fifo_full, push, pop, adv_en;
  logic [ADDR_W-1:0]   base, wb_addr;
  logic [31:0]         wptr, rptr, wptr_next;
  logic [PKT_BITS-1:0] pkt;
  wr_state_t           state;

  assign in_req    = '{client: req_client, source: req_source, ring: req_ring, ctx: req_ctx};
  assign req_ready = !fifo_full;
  assign push      = req_valid && !fifo_full && req_legal(in_req);
  assign pop       = (state == ST_IDLE) && !fifo_empty && (wptr_next != rptr);
  assign adv_en    = (state == ST_PKT_WAIT) && dma_done && (dma_done_tag == TAG_PKT);

  irq_req_fifo #(.W(REQ_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(push), .din(in_req), .pop(pop),
    .dout(head_req), .empty(fifo_empty), .full(fifo_full)
  );

  irq_ring_regs #(.SZ_W(4), .SZ_MAX(SZ_MAX)) regs_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_off(cfg_wr_off),
    .wr_data(cfg_wr_data), .db_valid(db_valid), .db_offset(db_offset),
    .db_data(db_data), .adv_en(adv_en), .base(base), .wb_addr(wb_addr),
    .wptr(wptr), .rptr(rptr), .wptr_next(wptr_next)
  );

  irq_pkt_pack pack_i (.req(head_req), .pkt(pkt));

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      dma_req_valid <= 1'b0;
      dma_req_addr  <= '0;
      dma_req_data  <= '0;
      dma_req_len   <= '0;
      dma_req_tag   <= '0;
      host_irq      <= 1'b0;
      ring_full     <= 1'b0;
      dma_err       <= 1'b0;
    end else begin
      host_irq  <= 1'b0;
      dma_err   <= 1'b0;
      ring_full <= (wptr_next == rptr);
      unique case (state)
        ST_IDLE: begin
          if (pop) state <= ST_LOAD;
          if (dma_done) dma_err <= 1'b1;
        end
        ST_LOAD: begin
          dma_req_valid <= 1'b1;
          dma_req_addr  <= base + {32'h0, wptr};
          dma_req_data  <= pkt;
          dma_req_len   <= LEN_W'(PKT_BYTES);
          dma_req_tag   <= TAG_PKT;
          state         <= ST_PKT_REQ;
          if (dma_done) dma_err <= 1'b1;
        end
        ST_PKT_REQ, ST_PTR_REQ: begin
          if (dma_req_accept) begin
            dma_req_valid <= 1'b0;
            state <= (state == ST_PKT_REQ) ? ST_PKT_WAIT : ST_PTR_WAIT;
          end
          if (dma_done) dma_err <= 1'b1;
        end
        ST_PKT_WAIT: begin
          if (dma_done) begin
            if (dma_done_tag == TAG_PKT) begin
              dma_req_valid <= 1'b1;
              dma_req_addr  <= wb_addr;
              dma_req_data  <= {{(PKT_BITS-32){1'b0}}, wptr_next};
              dma_req_len   <= LEN_W'(4);
              dma_req_tag   <= TAG_PTR;
              state         <= ST_PTR_REQ;
            end else begin
              dma_err <= 1'b1;
            end
          end
        end
        ST_PTR_WAIT: begin
          if (dma_done) begin
            if (dma_done_tag == TAG_PTR) begin
              host_irq <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              dma_err <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_ring_writer_chk.sv
module irq_ring_writer_chk
  import irq_ring_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                dma_req_valid,
  input logic                dma_req_accept,
  input logic [ADDR_W-1:0]   dma_req_addr,
  input logic [PKT_BITS-1:0] dma_req_data,
  input logic [LEN_W-1:0]    dma_req_len,
  input logic [TAG_W-1:0]    dma_req_tag,
  input logic                dma_done,
  input logic [TAG_W-1:0]    dma_done_tag,
  input logic                host_irq,
  input logic                dma_err
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid && !dma_req_accept |=> dma_req_valid && $stable(dma_req_addr) && $stable(dma_req_tag)); // R2

  AST_PKT_SHAPE: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid && dma_req_tag == TAG_PKT |-> dma_req_len == 6'd32
      && dma_req_data[127:96] == 32'h0000_8000 && dma_req_data[63:32] == 32'h0000_0040); // R3

  AST_PTR_SHAPE: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid && dma_req_tag != TAG_PKT |-> dma_req_tag == TAG_PTR && dma_req_len == 6'd4
      && dma_req_data[PKT_BITS-1:32] == '0); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    host_irq |=> !host_irq); // R5

  AST_IRQ_AFTER_PTR_DONE: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> $past(dma_done) && $past(dma_done_tag) == TAG_PTR); // R5

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dma_err |-> $past(dma_done)); // R6

  AST_IRQ_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> !dma_req_valid); // R5
endmodule

bind irq_ring_writer irq_ring_writer_chk chk_i (
  .clk(clk), .rst(rst), .dma_req_valid(dma_req_valid), .dma_req_accept(dma_req_accept),
  .dma_req_addr(dma_req_addr), .dma_req_data(dma_req_data), .dma_req_len(dma_req_len),
  .dma_req_tag(dma_req_tag), .dma_done(dma_done), .dma_done_tag(dma_done_tag),
  .host_irq(host_irq), .dma_err(dma_err)
);

// File: tb/irq_ring_writer_tb_top.sv
`timescale 1ns/1ps
module irq_ring_writer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         cfg_wr_en = 0;
  logic [3:0]   cfg_wr_off = 0;
  logic [31:0]  cfg_wr_data = 0;
  logic         db_valid = 0;
  logic [25:0]  db_offset = 0;
  logic [31:0]  db_data = 0;
  logic         req_valid = 0, req_ready;
  logic [7:0]   req_client = 0, req_source = 0, req_ring = 0;
  logic [31:0]  req_ctx = 0;
  logic         dma_req_valid, dma_req_accept = 1;
  logic [63:0]  dma_req_addr;
  logic [255:0] dma_req_data;
  logic [5:0]   dma_req_len;
  logic [1:0]   dma_req_tag;
  logic         dma_done = 0;
  logic [1:0]   dma_done_tag = 0;
  logic         host_irq, ring_full, dma_err;

  irq_ring_writer #(.FIFO_DEPTH(4), .SZ_MAX(12)) dut_i (.*);

  localparam logic [63:0] BASE = 64'h0000_AB00_1234_5600;
  localparam logic [63:0] WB   = 64'h0000_0007_CAFE_0040;

  // {legal, client, source, ring, ctx}
  localparam logic [56:0] VEC [8] = '{
    {1'b1, 8'h01, 8'h05, 8'h00, 32'h0000_1111},
    {1'b1, 8'h10, 8'h0A, 8'h01, 32'h2222_0001},
    {1'b0, 8'h30, 8'h05, 8'h02, 32'hDEAD_0002},
    {1'b1, 8'h17, 8'h05, 8'h02, 32'h3333_0002},
    {1'b0, 8'h20, 8'h07, 8'h03, 32'hDEAD_0004},
    {1'b1, 8'h20, 8'h0A, 8'h03, 32'h4444_0003},
    {1'b1, 8'h14, 8'h05, 8'h04, 32'h5555_0004},
    {1'b0, 8'h18, 8'h05, 8'h05, 32'hDEAD_0006}
  };

  int nchk = 0, nfail = 0;
  logic [31:0] exp_wptr = 0;
  logic [31:0] ring_bytes = 0;

  task automatic chk(input bit ok, input string r, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_off = off; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic ring_db(input logic [25:0] off, input logic [31:0] d);
    @(negedge clk);
    db_valid = 1; db_offset = off; db_data = d;
    @(negedge clk);
    db_valid = 0;
  endtask

  task automatic push(input logic [7:0] c, input logic [7:0] s, input logic [7:0] rg, input logic [31:0] x);
    @(negedge clk);
    req_valid = 1; req_client = c; req_source = s; req_ring = rg; req_ctx = x;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_req(output bit found);
    found = 0;
    for (int i = 0; i < 60; i++) begin
      if (dma_req_valid && dma_req_accept) begin found = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string r);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dma_req_valid) seen = 1;
    end
    chk(!seen, r, 256'(seen), 256'(0));
  endtask

  function automatic logic [255:0] model_pkt(logic [7:0] c, logic [7:0] s, logic [7:0] rg, logic [31:0] x);
    logic [255:0] p = '0;
    p[7:0] = c; p[15:8] = s; p[23:16] = rg;
    p[63:32] = 32'h40;
    p[127:96] = 32'h8000;
    p[191:160] = x;
    return p;
  endfunction

  task automatic serve(input logic [7:0] c, input logic [7:0] s, input logic [7:0] rg,
                       input logic [31:0] x, input bit bad_tag);
    bit found;
    logic [31:0] nxt = (exp_wptr + 32) % ring_bytes;
    wait_req(found);
    chk(found, "R2 packet request issued", 256'(found), 256'(1));
    chk(dma_req_addr == BASE + {32'h0, exp_wptr}, "R2 packet address", 256'(dma_req_addr), 256'(BASE + {32'h0, exp_wptr}));
    chk(dma_req_len == 32 && dma_req_tag == 1, "R2 packet len/tag", 256'({dma_req_len, dma_req_tag}), 256'({6'd32, 2'd1}));
    chk(dma_req_data == model_pkt(c, s, rg, x), "R3 packet content", dma_req_data, model_pkt(c, s, rg, x));
    if (bad_tag) begin
      @(negedge clk); dma_done = 1; dma_done_tag = 2'd3;
      @(negedge clk); dma_done = 0;
      chk(dma_err == 1, "R6 bad tag flagged", 256'(dma_err), 256'(1));
      @(negedge clk);
      chk(dma_req_valid == 0 && host_irq == 0, "R6 still waiting", 256'({dma_req_valid, host_irq}), 256'(0));
    end
    @(negedge clk); dma_done = 1; dma_done_tag = 2'd1;
    @(negedge clk); dma_done = 0;
    chk(host_irq == 0, "R5 no irq after packet phase", 256'(host_irq), 256'(0));
    wait_req(found);
    chk(found && dma_req_addr == WB, "R4 pointer write address", 256'(dma_req_addr), 256'(WB));
    chk(dma_req_len == 4 && dma_req_tag == 2, "R4 pointer len/tag", 256'({dma_req_len, dma_req_tag}), 256'({6'd4, 2'd2}));
    chk(dma_req_data[31:0] == nxt, "R4 new write offset", 256'(dma_req_data[31:0]), 256'(nxt));
    @(negedge clk); dma_done = 1; dma_done_tag = 2'd2;
    @(negedge clk); dma_done = 0;
    chk(host_irq == 1, "R5 irq after pointer done", 256'(host_irq), 256'(1));
    @(negedge clk);
    chk(host_irq == 0, "R5 irq one cycle", 256'(host_irq), 256'(0));
    exp_wptr = nxt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && {dma_req_valid, host_irq, ring_full, dma_err} == 4'b0, "R11 reset state",
        256'({req_ready, dma_req_valid, host_irq, ring_full, dma_err}), 256'(5'b10000));
    rst = 0;

    wr(4'd1, 32'h0012_3456);
    wr(4'd2, 32'h0000_00AB);
    wr(4'd5, 32'hCAFE_0040);
    wr(4'd6, 32'h0000_0007);
    wr(4'd3, 32'h0);
    wr(4'd0, 32'd3); ring_bytes = 256;

    // R7, R2, R3, R4, R5: vector table
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:0]);
      if (VEC[i][56]) serve(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:0], 0);
      else quiet(15, "R7 illegal request dropped");
    end

    // R6: bad completion tag mid-sequence
    push(8'h15, 8'h05, 8'h07, 32'h6666_0000);
    serve(8'h15, 8'h05, 8'h07, 32'h6666_0000, 1);

    // R8: order and back-pressure
    wr(4'd0, 32'd4); ring_bytes = 512;
    dma_req_accept = 0;
    push(8'h10, 8'h05, 8'h00, 32'h7000_0000);
    repeat (5) @(negedge clk);
    for (int k = 1; k < 5; k++) push(8'h10, 8'h05, 8'(k), 32'h7000_0000 + k);
    @(negedge clk);
    chk(req_ready == 0, "R8 ready low when queue full", 256'(req_ready), 256'(0));
    dma_req_accept = 1;
    for (int k = 0; k < 5; k++) serve(8'h10, 8'h05, 8'(k), 32'h7000_0000 + k, 0);

    // R9: ring full at a four-entry ring, R1 write offset store
    wr(4'd4, 32'h0); exp_wptr = 0;
    wr(4'd0, 32'd2); ring_bytes = 128;
    wr(4'd3, 32'h0);
    for (int k = 0; k < 3; k++) begin
      push(8'h01, 8'h0A, 8'h09, 32'h8000_0000 + k);
      serve(8'h01, 8'h0A, 8'h09, 32'h8000_0000 + k, 0);
    end
    push(8'h01, 8'h0A, 8'h09, 32'h8000_0003);
    quiet(10, "R9 packet held while ring full");
    chk(ring_full == 1, "R9 ring_full reported", 256'(ring_full), 256'(1));
    wr(4'd3, 32'd32);
    serve(8'h01, 8'h0A, 8'h09, 32'h8000_0003, 0);
    chk(exp_wptr == 0, "R4 wrap to zero at ring top", 256'(exp_wptr), 256'(0));

    // R10: doorbell read-offset return
    push(8'h20, 8'h05, 8'h0B, 32'h9000_0000);
    wr(4'd7, 32'h03AB_CDEF);
    ring_db(26'h3AB_CDEF, 32'd64);
    quiet(10, "R10 disabled doorbell ignored");
    wr(4'd7, 32'h1BAB_CDEF);
    ring_db(26'h3AB_CDE0, 32'd64);
    quiet(10, "R10 wrong doorbell offset ignored");
    ring_db(26'h3AB_CDEF, 32'd64);
    serve(8'h20, 8'h05, 8'h0B, 32'h9000_0000, 0);

    // R12: writes to unused offsets
    wr(4'd3, 32'h0);
    for (int k = 8; k < 16; k++) wr(4'(k), 32'hFFFF_FFFF);
    push(8'h12, 8'h0A, 8'h0C, 32'hA000_0000);
    serve(8'h12, 8'h0A, 8'h0C, 32'hA000_0000, 0);
    chk(exp_wptr == 64, "R12 R1 state intact after unused offsets", 256'(exp_wptr), 256'(64));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule